// File: doc/BRIEF.md
# Hit and Miss Performance Monitor

This block counts cache lookup outcomes for performance analysis. The lookup logic sends one-cycle strobes, one for a hit and one for a miss. The block keeps a separate counter for each kind of event. Software controls each counter through a small control word: one run bit per counter and one clear bit per counter. A clear bit that is held at 1 keeps its counter at zero until software writes it back to 0.

Counters stop at their all-ones value and never wrap to zero. Stopping a counter freezes its value so that it can be read later. A small registered read port returns the control word or either counter value. Read data appears one cycle after the request.

Top module: `hitmiss_monitor`

## Requirements
- R1: Each counter is CNT_W bits wide (default 32). In a cycle where the counter's strobe and its run bit are both 1, the counter rises by exactly one at the next clock edge. In any other cycle it changes only when it is cleared.
- R2: A counter at all-ones stays at all-ones when further strobes arrive, and does not wrap to zero.
- R3: The hit counter is gated by control bit 0 and the miss counter by control bit 1. Either counter can run while the other is stopped.
- R4: While its run bit is 0, a counter keeps its value unchanged, even when strobes arrive.
- R5: The hit counter's clear bit is control bit 2 and the miss counter's clear bit is control bit 3. While a clear bit is 1, its counter reads zero. Counting resumes from zero after the bit is written back to 0.
- R6: A clear bit that is 1 wins over a strobe and a run bit in the same cycle: the counter stays at zero.
- R7: After a synchronous reset, both counters are zero, the control word is zero and rd_valid is 0.
- R8: A control write is registered at the clock edge where ctrl_we is 1. The new value first affects counting at the following edge.
- R9: A read with rd_en=1 returns its data one cycle later, with rd_valid=1 in that cycle and rd_valid=0 otherwise. The rd_sel codes are: 0 returns the control word zero-extended, 1 returns the hit counter, 2 returns the miss counter, 3 returns zero. rd_data holds its last value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_evt | input | 1 | One-cycle hit strobe from the lookup logic |
| miss_evt | input | 1 | One-cycle miss strobe from the lookup logic |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wdata | input | 4 | New control word: bits 0-1 are run bits, bits 2-3 are clear bits |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Read selection code |
| rd_data | output | CNT_W | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read request |
| hit_count | output | CNT_W | Current hit counter value |
| miss_count | output | CNT_W | Current miss counter value |

## Verification
The bound assertions check the following properties on every cycle, for both counters:
- a counter steps by at most one, and only when its strobe and its run bit are both present;
- a counter at all-ones stays there;
- a clear bit forces zero, including when it collides with a strobe;
- rd_valid follows rd_en by exactly one cycle.

Other behaviour can only be shown by the bench scenarios, which compare against a reference model:
- that a control write takes effect one edge late;
- that the two counters run independently;
- that counting resumes correctly after a clear is released;
- that the read codes map to the right values.

A second instance with 8-bit counters lets the bench reach saturation within a short run.

// File: rtl/hmmon_pkg.sv
package hmmon_pkg;
  localparam int unsigned NUM_CNT  = 2;
  localparam int unsigned CTRL_W   = 2 * NUM_CNT;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned IDX_HIT  = 0;
  localparam int unsigned IDX_MISS = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_HIT  = 2'd1,
    SEL_MISS = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/hmmon_sat_counter.sv
module hmmon_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic         evt,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic at_max;
  logic bump;

  assign at_max = (count == MAXV);
  assign bump   = run && evt && !at_max;

  // clear has priority over a count in the same cycle
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (bump) begin
      count <= count + ONE;
    end
  end
endmodule

// File: rtl/hmmon_ctrl.sv
module hmmon_ctrl #(
  parameter int unsigned N = 2,
  localparam int unsigned CW = 2 * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [N-1:0]  run,
  output logic [N-1:0]  clr,
  output logic [CW-1:0] word
);
  logic [CW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (we) begin
      word_q <= wdata;
    end
  end

  // run bits low, clear bits N positions above their run bit
  assign run  = word_q[N-1:0];
  assign clr  = word_q[CW-1:N];
  assign word = word_q;
endmodule

// File: rtl/hmmon_readback.sv
module hmmon_readback
  import hmmon_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [CW-1:0]    ctrl_word,
  input  logic [W-1:0]     hit_val,
  input  logic [W-1:0]     miss_val,
  output logic [W-1:0]     rd_data,
  output logic             rd_valid
);
  logic [W-1:0] mux_val;
  logic [W-1:0] ctrl_ext;

  assign ctrl_ext = {{(W-CW){1'b0}}, ctrl_word};

  always_comb begin
    case (rd_sel)
      SEL_CTRL: mux_val = ctrl_ext;
      SEL_HIT:  mux_val = hit_val;
      SEL_MISS: mux_val = miss_val;
      default:  mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= mux_val;
      end
    end
  end
endmodule

// File: rtl/hitmiss_monitor.sv
module hitmiss_monitor
  import hmmon_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_evt,
  input  logic             miss_evt,
  input  logic             ctrl_we,
  input  logic [3:0]       ctrl_wdata,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_valid,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  logic [NUM_CNT-1:0] run_w;
  logic [NUM_CNT-1:0] clr_w;
  logic [CTRL_W-1:0]  ctrl_word;
  logic [NUM_CNT-1:0] evt_vec;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

  assign evt_vec[IDX_HIT]  = hit_evt;
  assign evt_vec[IDX_MISS] = miss_evt;

  hmmon_ctrl #(.N(NUM_CNT)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctrl_we),
    .wdata (ctrl_wdata),
    .run   (run_w),
    .clr   (clr_w),
    .word  (ctrl_word)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    hmmon_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr_w[g]),
      .run   (run_w[g]),
      .evt   (evt_vec[g]),
      .count (cnt_arr[g])
    );
  end

  assign hit_count  = cnt_arr[IDX_HIT];
  assign miss_count = cnt_arr[IDX_MISS];

  hmmon_readback #(.W(CNT_W), .CW(CTRL_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .ctrl_word (ctrl_word),
    .hit_val   (cnt_arr[IDX_HIT]),
    .miss_val  (cnt_arr[IDX_MISS]),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );
endmodule

// File: rtl/hitmiss_monitor_chk.sv
module hitmiss_monitor_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             hit_evt,
  input logic             miss_evt,
  input logic [1:0]       run_q,
  input logic [1:0]       clr_q,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic             rd_en,
  input logic             rd_valid
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  // R1: step is zero or one when not cleared
  assert_hit_step_R1: assert property (@(posedge clk) disable iff (rst)
    !clr_q[0] |=> (hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + ONE));
  assert_miss_step_R1: assert property (@(posedge clk) disable iff (rst)
    !clr_q[1] |=> (miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + ONE));

  // R4: no strobe-with-run and no clear means the value holds
  assert_hit_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr_q[0] && !(run_q[0] && hit_evt)) |=> $stable(hit_count));
  assert_miss_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr_q[1] && !(run_q[1] && miss_evt)) |=> $stable(miss_count));

  // R2: saturation holds
  assert_hit_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr_q[0] && hit_count == MAXV) |=> hit_count == MAXV);
  assert_miss_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr_q[1] && miss_count == MAXV) |=> miss_count == MAXV);

  // R5: clear forces zero
  assert_hit_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr_q[0] |=> hit_count == '0);
  assert_miss_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr_q[1] |=> miss_count == '0);

  // R6: clear wins over a simultaneous count
  assert_hit_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_q[0] && run_q[0] && hit_evt) |=> hit_count == '0);
  assert_miss_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_q[1] && run_q[1] && miss_evt) |=> miss_count == '0);

  // R9: valid follows request by one cycle
  assert_rd_valid_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_rd_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

bind hitmiss_monitor hitmiss_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hit_evt    (hit_evt),
  .miss_evt   (miss_evt),
  .run_q      (run_w),
  .clr_q      (clr_w),
  .hit_count  (hit_count),
  .miss_count (miss_count),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid)
);

// File: tb/tb_hitmiss_monitor.sv
`timescale 1ns/1ps
module tb_hitmiss_monitor;
  localparam int BIG_W = 32;
  localparam int SML_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hit_evt = 1'b0, miss_evt = 1'b0;
  logic ctrl_we = 1'b0;
  logic [3:0] ctrl_wdata = 4'd0;
  logic rd_en = 1'b0;
  logic [1:0] rd_sel = 2'd0;

  logic [BIG_W-1:0] b_rd, b_hit, b_miss;
  logic [SML_W-1:0] s_rd, s_hit, s_miss;
  logic b_vld, s_vld;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hitmiss_monitor #(.CNT_W(BIG_W)) dut (
    .clk(clk), .rst(rst), .hit_evt(hit_evt), .miss_evt(miss_evt),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(b_rd), .rd_valid(b_vld), .hit_count(b_hit), .miss_count(b_miss));

  hitmiss_monitor #(.CNT_W(SML_W)) dut_small (
    .clk(clk), .rst(rst), .hit_evt(hit_evt), .miss_evt(miss_evt),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(s_rd), .rd_valid(s_vld), .hit_count(s_hit), .miss_count(s_miss));

  // reference model: index 0 = 32-bit instance, 1 = 8-bit instance
  longint m_cnt [2][2];
  longint m_rd [2];
  bit     m_vld;
  int     m_ctrl;
  longint m_max [2];

  initial begin
    m_max[0] = 64'hFFFF_FFFF;
    m_max[1] = 255;
  end

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i][0] = 0; m_cnt[i][1] = 0; m_rd[i] = 0;
      end
      m_vld = 0; m_ctrl = 0;
    end else begin
      m_vld = rd_en;
      for (int i = 0; i < 2; i++) begin
        if (rd_en) begin
          case (rd_sel)
            2'd0: m_rd[i] = m_ctrl;
            2'd1: m_rd[i] = m_cnt[i][0];
            2'd2: m_rd[i] = m_cnt[i][1];
            default: m_rd[i] = 0;
          endcase
        end
        for (int k = 0; k < 2; k++) begin
          if (m_ctrl[2+k]) m_cnt[i][k] = 0;
          else if (m_ctrl[k] && (k == 0 ? hit_evt : miss_evt) && m_cnt[i][k] < m_max[i])
            m_cnt[i][k] = m_cnt[i][k] + 1;
        end
      end
      if (ctrl_we) m_ctrl = ctrl_wdata;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R1 big hit",   b_hit,  m_cnt[0][0]);
      chk("R1 big miss",  b_miss, m_cnt[0][1]);
      chk("R1 small hit", s_hit,  m_cnt[1][0]);
      chk("R1 small miss",s_miss, m_cnt[1][1]);
      chk("R9 big valid", b_vld,  m_vld);
      chk("R9 small valid", s_vld, m_vld);
      chk("R9 big data",  b_rd,   m_rd[0]);
      chk("R9 small data",s_rd,   m_rd[1]);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [3:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    step(1);
    ctrl_we = 1'b0;
  endtask

  task automatic pulse(logic h, logic m, int n);
    hit_evt = h; miss_evt = m;
    step(n);
    hit_evt = 1'b0; miss_evt = 1'b0;
  endtask

  task automatic do_read(logic [1:0] s);
    rd_en = 1'b1; rd_sel = s;
    step(1);
    rd_en = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    chk("R7 hit zero", b_hit, 0);
    chk("R7 miss zero", b_miss, 0);
    chk("R7 valid low", b_vld, 0);
    do_read(2'd0);
    chk("R7 ctrl zero", b_rd, 0);

    // R8: event in the write cycle is not counted
    ctrl_we = 1'b1; ctrl_wdata = 4'b0011; hit_evt = 1'b1;
    step(1);
    ctrl_we = 1'b0; hit_evt = 1'b0;
    chk("R8 write latency", b_hit, 0);

    pulse(1, 0, 5);
    pulse(1, 1, 3);
    chk("R1 hit count", b_hit, 8);
    chk("R1 miss count", b_miss, 3);

    do_read(2'd1); chk("R9 read hit", b_rd, 8); chk("R9 valid", b_vld, 1);
    do_read(2'd2); chk("R9 read miss", b_rd, 3);
    do_read(2'd0); chk("R9 read ctrl", b_rd, 3);
    do_read(2'd3); chk("R9 read none", b_rd, 0);
    step(1); chk("R9 valid drops", b_vld, 0); chk("R9 data holds", b_rd, 0);

    wr_ctrl(4'b0010);
    pulse(1, 1, 4);
    chk("R3 hit stopped", b_hit, 8);
    chk("R3 miss runs", b_miss, 7);

    wr_ctrl(4'b0000);
    pulse(1, 1, 6);
    chk("R4 hit kept", b_hit, 8);
    chk("R4 miss kept", b_miss, 7);

    wr_ctrl(4'b0111);
    pulse(1, 1, 3);
    chk("R6 hit held zero", b_hit, 0);
    chk("R5 miss unaffected", b_miss, 10);
    wr_ctrl(4'b0011);
    pulse(1, 0, 2);
    chk("R5 hit resumes", b_hit, 2);

    pulse(1, 0, 300);
    chk("R2 small saturates", s_hit, 255);
    chk("R2 big counts on", b_hit, 302);
    pulse(1, 0, 5);
    chk("R2 small no wrap", s_hit, 255);
    chk("R2 big", b_hit, 307);
    do_read(2'd1); chk("R9 small read sat", s_rd, 255);

    wr_ctrl(4'b0111);
    wr_ctrl(4'b0011);
    chk("R5 small cleared", s_hit, 0);
    chk("R5 miss kept", s_miss, 10);
    step(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule